// File: doc/BRIEF.md
# Serial Avionics Word Transmitter with Fault Insertion

This block sends 32-bit avionics data words on one two-wire bipolar return-to-zero link. The host pushes words into a local 256-entry queue. While the transmitter is enabled and the queue holds data, the block takes one word at a time, serialises it least significant bit first and drives the high and low line outputs. Between words it holds the line null for at least the programmed gap, then starts the next word without any host action.

A set of static controls chooses the bit rate, the minimum gap and how the word is formatted. The word can carry a generated parity bit, a deliberately wrong parity bit or the bit exactly as written. The word can also be cut to 31 bits or stretched to 33 bits. These options let a test rig inject malformed traffic. A loop-back control moves the serial stream from the external pins to a pair of internal outputs that feed a local receiver, and forces the external pins to null.

The controls are sampled when a word leaves the queue. Changing them during a word affects only the following words.

Top module: `a429_tx`

## Requirements
- R1: The queue holds up to 256 words of 32 bits. `full` is high exactly when 256 words are held. A write while `full` is high is discarded.
- R2: While `tx_en` is high and the queue is not empty, the next word starts without host action, and words keep following until the queue is empty. While `tx_en` is low no new word starts, but a word already started runs to its end.
- R3: Bit 0 of the frame is sent first. Each bit time is two half periods. In the first half, `hi` is 1 for a one bit or `lo` is 1 for a zero bit. In the second half both are 0. Both are 0 while no word is on the line.
- R4: A half period lasts (min(`rate_code`,124)+1) base ticks. A base tick occurs once every BASE_CYC clocks from a free-running prescaler.
- R5: With `par_gen`=1, bit 31 is replaced so that the 32 bits hold an odd number of ones. `par_flip`=1 then inverts that bit.
- R6: With `par_gen`=0, bit 31 is sent as written and `par_flip` has no effect.
- R7: `len_sel` 0 or 3 sends 32 bits. A value of 1 sends bits 0 to 30 only. A value of 2 sends the 32 bits followed by one extra zero bit.
- R8: After the last bit of a word, the line stays null for max(`gap_bits`,4) bit times (2× that many half periods) before the next word can start.
- R9: With `loopback`=1 the external `line_hi`/`line_lo` stay 0 and `lb_hi`/`lb_lo` carry the stream. With `loopback`=0, `lb_hi`/`lb_lo` stay 0.
- R10: After reset all line outputs are 0, `full` is 0 and the queue is empty.
- R11: Rate, gap, parity and length settings are captured when a word leaves the queue. Changes made during that word apply from the next word on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| loopback | input | 1 | Route stream to internal outputs, null the external pins |
| rate_code | input | 7 | Half-period length in base ticks minus one (clamped at 124) |
| gap_bits | input | 6 | Minimum inter-word gap in bit times (raised to 4) |
| par_gen | input | 1 | Replace bit 31 with odd parity |
| par_flip | input | 1 | Invert the generated parity |
| len_sel | input | 2 | Word length: 0/3 = 32, 1 = 31, 2 = 33 bits |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 32 | Word to queue |
| full | output | 1 | Queue holds 256 words |
| line_hi | output | 1 | External high line |
| line_lo | output | 1 | External low line |
| lb_hi | output | 1 | Loop-back high line |
| lb_lo | output | 1 | Loop-back low line |

## Verification
The assertions check several rules on every cycle:
- a word is taken from the queue only when the queue is non-empty and `tx_en` is high;
- a push into a full queue leaves the fill level unchanged;
- the latched half period and gap stay within their clamped ranges;
- latched settings stay constant for the whole of a word;
- base ticks never come back to back.

The bench's behavioural model compares the line outputs on every clock. Only its scenarios can show the following:
- the bit order, the parity values and the truncated or stretched frames;
- the exact gap length;
- the effect of a disable part-way through a word;
- the discarding of writes to a full queue, which is seen as the count of words sent after draining 256.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

    localparam int WORD_W  = 32;
    localparam int FRAME_W = 33;

    localparam logic [6:0] RATE_CODE_MAX = 7'd124;
    localparam logic [5:0] GAP_MIN       = 6'd4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BIT  = 2'd1,
        ST_GAP  = 2'd2
    } ser_state_e;

    typedef struct packed {
        ser_state_e         st;
        logic [FRAME_W-1:0] sr;
        logic [5:0]         bits_left;
        logic               phase;
        logic [6:0]         tcnt;
        logic [6:0]         half;
        logic [5:0]         gap;
        logic [6:0]         gcnt;
    } ser_regs_t;

    // Half period in base ticks, with the rate code clamped at the top code.
    function automatic logic [6:0] half_ticks(input logic [6:0] code);
        logic [6:0] c;
        c = (code > RATE_CODE_MAX) ? RATE_CODE_MAX : code;
        return c + 7'd1;
    endfunction

    // Gap in bit times, raised to the minimum.
    function automatic logic [5:0] eff_gap(input logic [5:0] g);
        return (g < GAP_MIN) ? GAP_MIN : g;
    endfunction

endpackage

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
    parameter int DEPTH = 256,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] data_o,
    output logic         empty_o,
    output logic         full_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_regs_t;

    fifo_regs_t  r_d, r_q;
    logic [W-1:0] mem_q [DEPTH];
    logic         accept, take;

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign empty_o = (r_q.cnt == '0);
    assign full_o  = (r_q.cnt == FULL_CNT);
    assign accept  = push_i && !full_o;
    assign take    = pop_i && !empty_o;
    assign data_o  = mem_q[r_q.rp];

    always_comb begin
        r_d = r_q;
        if (accept) r_d.wp = next_ptr(r_q.wp);
        if (take)   r_d.rp = next_ptr(r_q.rp);
        unique case ({accept, take})
            2'b10:   r_d.cnt = r_q.cnt + 1'b1;
            2'b01:   r_d.cnt = r_q.cnt - 1'b1;
            default: r_d.cnt = r_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem_q[r_q.wp] <= data_i;
    end

    // R1: a push into a full queue without a pop leaves the level unchanged
    p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i) |=> (full_o && $stable(r_q.cnt)))
        else $error("queue level changed on push while full");

    // R2: the serializer never pops an empty queue
    p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o)
        else $error("pop while empty");

endmodule

// File: rtl/a429_tx_presc.sv
module a429_tx_presc #(
    parameter int BASE_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int PW = (BASE_CYC > 1) ? $clog2(BASE_CYC) : 1;
    localparam logic [PW-1:0] LAST = PW'(BASE_CYC - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_comb begin
        cnt_d = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (BASE_CYC > 1) begin : g_spacing_chk
            // R4: base ticks are separated by idle clocks
            p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o)
                else $error("base ticks back to back");
        end
    endgenerate

endmodule

// File: rtl/a429_tx_fmt.sv
module a429_tx_fmt
    import a429_tx_pkg::*;
(
    input  logic [WORD_W-1:0]  word_i,
    input  logic               par_gen_i,
    input  logic               par_flip_i,
    input  logic [1:0]         len_sel_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [5:0]         nbits_o
);

    logic [WORD_W-1:0] w;

    always_comb begin
        w = word_i;
        if (par_gen_i) begin
            w[WORD_W-1] = ~(^word_i[WORD_W-2:0]) ^ par_flip_i;
        end
        frame_o = {1'b0, w};
        unique case (len_sel_i)
            2'd1:    nbits_o = 6'd31;
            2'd2:    nbits_o = 6'd33;
            default: nbits_o = 6'd32;
        endcase
    end

endmodule

// File: rtl/a429_tx_ser.sv
module a429_tx_ser
    import a429_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               tick_i,
    input  logic               empty_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [5:0]         nbits_i,
    input  logic [6:0]         half_i,
    input  logic [5:0]         gap_i,
    output logic               pop_o,
    output logic               hi_o,
    output logic               lo_o
);

    ser_regs_t r_d, r_q;
    logic      half_end;
    logic      drive;

    assign half_end = tick_i && (r_q.tcnt == r_q.half - 7'd1);

    always_comb begin
        r_d   = r_q;
        pop_o = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (en_i && !empty_i) begin
                    pop_o       = 1'b1;
                    r_d.st        = ST_BIT;
                    r_d.sr        = frame_i;
                    r_d.bits_left = nbits_i;
                    r_d.phase     = 1'b0;
                    r_d.tcnt      = '0;
                    r_d.half      = half_i;
                    r_d.gap       = gap_i;
                    r_d.gcnt      = '0;
                end
            end
            ST_BIT: begin
                if (half_end) begin
                    r_d.tcnt = '0;
                    if (!r_q.phase) begin
                        r_d.phase = 1'b1;
                    end else begin
                        r_d.phase     = 1'b0;
                        r_d.sr        = {1'b0, r_q.sr[FRAME_W-1:1]};
                        r_d.bits_left = r_q.bits_left - 6'd1;
                        if (r_q.bits_left == 6'd1) begin
                            r_d.st   = ST_GAP;
                            r_d.gcnt = '0;
                        end
                    end
                end else if (tick_i) begin
                    r_d.tcnt = r_q.tcnt + 7'd1;
                end
            end
            ST_GAP: begin
                if (half_end) begin
                    r_d.tcnt = '0;
                    if (r_q.gcnt == 7'({r_q.gap, 1'b0}) - 7'd1) r_d.st = ST_IDLE;
                    else                                      r_d.gcnt = r_q.gcnt + 7'd1;
                end else if (tick_i) begin
                    r_d.tcnt = r_q.tcnt + 7'd1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign drive = (r_q.st == ST_BIT) && !r_q.phase;
    assign hi_o  = drive && r_q.sr[0];
    assign lo_o  = drive && !r_q.sr[0];

    // R2: a word only starts while the transmitter is enabled
    p_start_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BIT && $past(r_q.st) == ST_IDLE) |-> $past(en_i))
        else $error("word started while disabled");

    // R4: the latched half period stays within the clamped range
    p_half_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |-> (r_q.half >= 7'd1 && r_q.half <= 7'd125))
        else $error("half period out of range");

    // R8: the latched gap never falls below the minimum
    p_gap_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_GAP) |-> (r_q.gap >= GAP_MIN))
        else $error("gap below minimum");

    // R7: the bit count in flight stays within the allowed lengths
    p_len_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BIT) |-> (r_q.bits_left >= 6'd1 && r_q.bits_left <= 6'd33))
        else $error("bit count out of range");

    // R11: settings latched for a word do not change until the word ends
    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |=> (r_q.st == ST_IDLE || ($stable(r_q.half) && $stable(r_q.gap))))
        else $error("latched settings changed mid-word");

endmodule

// File: rtl/a429_tx.sv
module a429_tx
    import a429_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 256,
    parameter int BASE_CYC   = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_en,
    input  logic        loopback,
    input  logic [6:0]  rate_code,
    input  logic [5:0]  gap_bits,
    input  logic        par_gen,
    input  logic        par_flip,
    input  logic [1:0]  len_sel,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic        full,
    output logic        line_hi,
    output logic        line_lo,
    output logic        lb_hi,
    output logic        lb_lo
);

    logic [WORD_W-1:0]  head_word;
    logic               q_empty;
    logic               pop;
    logic               tick;
    logic [FRAME_W-1:0] frame;
    logic [5:0]         nbits;
    logic               s_hi, s_lo;

    a429_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (wr_en),
        .data_i  (wr_data),
        .pop_i   (pop),
        .data_o  (head_word),
        .empty_o (q_empty),
        .full_o  (full)
    );

    a429_tx_presc #(.BASE_CYC(BASE_CYC)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    a429_tx_fmt u_fmt (
        .word_i     (head_word),
        .par_gen_i  (par_gen),
        .par_flip_i (par_flip),
        .len_sel_i  (len_sel),
        .frame_o    (frame),
        .nbits_o    (nbits)
    );

    a429_tx_ser u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (tx_en),
        .tick_i  (tick),
        .empty_i (q_empty),
        .frame_i (frame),
        .nbits_i (nbits),
        .half_i  (half_ticks(rate_code)),
        .gap_i   (eff_gap(gap_bits)),
        .pop_o   (pop),
        .hi_o    (s_hi),
        .lo_o    (s_lo)
    );

    assign line_hi = s_hi && !loopback;
    assign line_lo = s_lo && !loopback;
    assign lb_hi   = s_hi && loopback;
    assign lb_lo   = s_lo && loopback;

endmodule

// File: tb/a429_tx_tb_top.sv
module a429_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 2;
    localparam int DEPTH      = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, loopback = 1'b0;
    logic [6:0]  rate_code = '0;
    logic [5:0]  gap_bits = '0;
    logic        par_gen = 1'b0, par_flip = 1'b0;
    logic [1:0]  len_sel = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        full, line_hi, line_lo, lb_hi, lb_lo;

    a429_tx #(.FIFO_DEPTH(DEPTH), .BASE_CYC(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .loopback(loopback),
        .rate_code(rate_code), .gap_bits(gap_bits), .par_gen(par_gen),
        .par_flip(par_flip), .len_sel(len_sel), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .line_hi(line_hi), .line_lo(line_lo), .lb_hi(lb_hi), .lb_lo(lb_lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, scen_err = 0, sent = 0;
    bit done = 1'b0;

    // ---------------- behavioural reference model ----------------
    logic [31:0] mq[$];
    int m_pc, m_st, m_bl, m_ph, m_tc, m_half, m_gap, m_gc;
    logic [32:0] m_sr;

    function automatic logic [32:0] ref_frame(input logic [31:0] w, input bit g, input bit f);
        logic [31:0] x;
        int ones;
        x = w;
        if (g) begin
            ones = 0;
            for (int i = 0; i < 31; i++) ones += int'(w[i]);
            x[31] = ((ones % 2) == 0) ^ f;   // odd total
        end
        return {1'b0, x};
    endfunction

    function automatic int ref_len(input logic [1:0] s);
        return (s == 2'd1) ? 31 : (s == 2'd2) ? 33 : 32;
    endfunction

    task automatic model_reset();
        mq.delete();
        m_pc = 0; m_st = 0; m_bl = 0; m_ph = 0; m_tc = 0;
        m_half = 1; m_gap = 4; m_gc = 0; m_sr = '0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit tk, do_pop;
            int old_size;
            tk = (m_pc == BASE - 1);
            m_pc = tk ? 0 : m_pc + 1;
            old_size = mq.size();
            do_pop = 1'b0;
            if (m_st == 0) begin
                if (tx_en && old_size > 0) begin
                    do_pop = 1'b1;
                    m_sr   = ref_frame(mq[0], par_gen, par_flip);
                    m_bl   = ref_len(len_sel);
                    m_ph   = 0; m_tc = 0; m_gc = 0;
                    m_half = ((rate_code > 124) ? 124 : int'(rate_code)) + 1;
                    m_gap  = (gap_bits < 4) ? 4 : int'(gap_bits);
                    m_st   = 1;
                    sent++;
                end
            end else if (tk) begin
                if (m_tc == m_half - 1) begin
                    m_tc = 0;
                    if (m_st == 1) begin
                        if (m_ph == 0) m_ph = 1;
                        else begin
                            m_ph = 0; m_sr = m_sr >> 1; m_bl--;
                            if (m_bl == 0) begin m_st = 2; m_gc = 0; end
                        end
                    end else begin
                        if (m_gc == 2 * m_gap - 1) m_st = 0;
                        else m_gc++;
                    end
                end else m_tc++;
            end
            if (do_pop) void'(mq.pop_front());
            if (wr_en && old_size < DEPTH) mq.push_back(wr_data);
        end
    end

    // ---------------- per-clock comparison ----------------
    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            bit drv, eh, el;
            drv = (m_st == 1) && (m_ph == 0);
            eh = drv && m_sr[0];
            el = drv && !m_sr[0];
            if ({line_hi, line_lo} !== {eh && !loopback, el && !loopback}) scen_err++;
            chk({line_hi, line_lo} === {eh && !loopback, el && !loopback},
                "R3 line_hi/line_lo", {line_hi, line_lo}, {eh && !loopback, el && !loopback});
            if ({lb_hi, lb_lo} !== {eh && loopback, el && loopback}) scen_err++;
            chk({lb_hi, lb_lo} === {eh && loopback, el && loopback},
                "R9 lb_hi/lb_lo", {lb_hi, lb_lo}, {eh && loopback, el && loopback});
            chk(full === (mq.size() == DEPTH), "R1 full", full, mq.size() == DEPTH);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic push_words(input int n, input logic [31:0] seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_data = seed ^ (32'h9E3779B9 * (i + 1));
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60000; i++) begin
            @(negedge clk);
            if (mq.size() == 0 && m_st == 0) break;
        end
    endtask

    task automatic end_scen(input string tag, input int exp_sent);
        wait_idle();
        chk(scen_err == 0, {tag, " stream matches"}, scen_err, 0);
        chk(sent == exp_sent, {tag, " words sent"}, sent, exp_sent);
        scen_err = 0;
        sent = 0;
    endtask

    task automatic cfg(input int rc, input int gp, input bit g, input bit f, input int ls);
        @(negedge clk);
        rate_code = 7'(rc); gap_bits = 6'(gp); par_gen = g; par_flip = f; len_sel = 2'(ls);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({line_hi, line_lo, lb_hi, lb_lo} == 4'b0, "R10 outputs null in reset", {line_hi, line_lo, lb_hi, lb_lo}, 0);
        chk(full == 1'b0, "R10 full low in reset", full, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({line_hi, line_lo, full} == 3'b0, "R10 null after reset", {line_hi, line_lo, full}, 0);

        // R3 R5: generated odd parity, fastest rate
        cfg(0, 0, 1, 0, 0);
        tx_en = 1'b1;
        push_words(4, 32'h1234_5678);
        end_scen("R3 R5 odd parity", 4);

        // R5: inverted parity
        cfg(1, 0, 1, 1, 0);
        push_words(2, 32'hA5A5_0F0F);
        end_scen("R5 flipped parity", 2);

        // R6: raw bit 31, flip ignored
        cfg(0, 0, 0, 1, 0);
        push_words(1, 32'h8000_0000);
        push_words(1, 32'h0000_0003);
        end_scen("R6 raw bit 31", 2);

        // R7: lengths 31, 33 and the 32-bit alias code
        cfg(0, 0, 1, 0, 1);
        push_words(2, 32'hFFFF_0000);
        end_scen("R7 31-bit words", 2);
        cfg(0, 0, 0, 0, 2);
        push_words(2, 32'hFFFF_FFFF);
        end_scen("R7 33-bit words", 2);
        cfg(0, 0, 1, 0, 3);
        push_words(1, 32'h0F0F_F0F0);
        end_scen("R7 alias code 3", 1);

        // R8: programmed gap above minimum, and below minimum
        cfg(3, 9, 1, 0, 0);
        push_words(3, 32'h5555_AAAA);
        end_scen("R8 gap 9", 3);
        cfg(2, 1, 1, 0, 0);
        push_words(2, 32'h3C3C_C3C3);
        end_scen("R8 gap raised to 4", 2);

        // R4: mid rate and the clamped top code
        cfg(5, 4, 1, 0, 0);
        push_words(1, 32'h0000_1111);
        end_scen("R4 code 5", 1);
        cfg(127, 4, 1, 0, 0);
        push_words(1, 32'h7777_1234);
        end_scen("R4 code clamped", 1);

        // R11: settings changed mid-word only affect the next word
        cfg(2, 4, 1, 0, 0);
        push_words(2, 32'hDEAD_BEEF);
        repeat (20) @(negedge clk);
        cfg(0, 7, 0, 1, 2);
        end_scen("R11 latched settings", 2);

        // R2: disabled transmitter holds words, then releases them
        tx_en = 1'b0;
        cfg(0, 0, 1, 0, 0);
        push_words(3, 32'h0BAD_F00D);
        repeat (300) @(negedge clk);
        chk(sent == 0, "R2 no start while disabled", sent, 0);
        chk({line_hi, line_lo} == 2'b0, "R2 line null while disabled", {line_hi, line_lo}, 0);
        tx_en = 1'b1;
        end_scen("R2 release on enable", 3);

        // R2: disable during a word lets it finish, then stops
        push_words(3, 32'h1357_9BDF);
        for (int i = 0; i < 100 && m_st != 1; i++) @(negedge clk);
        tx_en = 1'b0;
        repeat (400) @(negedge clk);
        chk(sent == 1, "R2 current word completes then stops", sent, 1);
        chk(m_st == 0 && mq.size() == 2, "R2 remaining words held", mq.size(), 2);
        tx_en = 1'b1;
        end_scen("R2 resume", 3);

        // R9: loop-back routing
        loopback = 1'b1;
        push_words(2, 32'h2468_ACE0);
        end_scen("R9 loop-back", 2);
        loopback = 1'b0;

        // R1: fill to capacity, extra writes dropped
        tx_en = 1'b0;
        push_words(DEPTH + 2, 32'hC0FF_EE00);
        @(negedge clk);
        chk(full == 1'b1, "R1 full at capacity", full, 1);
        chk(mq.size() == DEPTH, "R1 model level", mq.size(), DEPTH);
        tx_en = 1'b1;
        end_scen("R1 drain of full queue", DEPTH);
        chk(full == 1'b0, "R1 full clears after drain", full, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule